// File: doc/BRIEF.md
# DMA Request Routing Table

This block sits between the peripherals of a chip and its DMA channels. Each hardware request ID owns one entry of a programmable table, and the entry names the channel that the request should start. A request line that goes high produces a one-cycle-delayed trigger on the channel it is mapped to. An entry holds the channel index plus one, so zero always means "not routed". ID 0 is kept for channels that software starts, and it has no entry at all.

The block also carries the pause handshake for every channel. Software sets a request bit in the channel's pause register. The block drives that bit to the channel. A status bit in the same register then reports when the channel has really stopped, which is once no beat is in flight. Clearing the request bit lets the channel run again.

Software reaches both register sets through a simple write port and a combinational read port.

Top module: `dma_req_router`

## Requirements
- R1: After reset, every table entry reads 0, every pause register reads 0, and both `chTrig` and `pauseReq` are all zero.
- R2: The entry for request ID n (1..NUM_IDS) is at byte address 0x2000 + 4*(n-1). A write stores the low CW bits of `wrData` and reads back unchanged. The new value governs requests from the cycle after the write, so a request in the same cycle as the write still uses the old entry.
- R3: With entry value v in 1..NUM_CH, a high `periphReq[n-1]` in a cycle makes `chTrig[v-1]` high in the next cycle, provided that channel is enabled.
- R4: A request whose entry is 0 produces no trigger. Writing 0 to an entry removes an earlier mapping.
- R5: ID 0 has no entry. A write to 0x1FFC, the address ID 0 would occupy, changes nothing and reads back 0. Bit i of `periphReq` is request ID i+1.
- R6: When several request IDs map to the same channel, their requests are ORed into that channel's single trigger.
- R7: A request to a channel whose `chEnable` bit is low is dropped. It does not fire when the channel is enabled later.
- R8: The pause register of channel c is at 0x1000 + 0x40*c. Writing bit 0 sets the pause request, which appears on `pauseReq[c]` in the next cycle and reads back in bit 0.
- R9: Pause status (read bit 2) becomes 1 one cycle after a cycle in which the pause request is set and `beatBusy[c]` is low. It stays 0 while a beat is in flight.
- R10: Writing 0 to bit 0 resumes the channel. `pauseReq[c]` drops in the next cycle, and the status bit drops one cycle after that, so the register reads 4 and then 0.
- R11: An entry value above NUM_CH is stored and read back, but it routes the request to no channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 16 | Byte address of the write |
| wrData | input | DW | Write data (DW = max(CW,3), CW = clog2(NUM_CH+1)) |
| rdAddr | input | 16 | Byte address of the read |
| rdData | output | DW | Read data, combinational from rdAddr |
| periphReq | input | NUM_IDS | Peripheral request lines, bit i is ID i+1 |
| chEnable | input | NUM_CH | Channel enable bits reported by the channels |
| beatBusy | input | NUM_CH | A channel has a beat in flight |
| chTrig | output | NUM_CH | One trigger per channel, registered |
| pauseReq | output | NUM_CH | Pause request to each channel |

## Verification
A table write and a peripheral request can land in the same cycle. The bench drives a new mapping for an ID and raises that ID's request on the same edge. It expects no trigger in that cycle and a trigger on the new channel in the next one. Two requests that converge on one channel can also fire together with a request to another channel. That case is judged by comparing the whole `chTrig` vector every cycle against a queue of expected vectors. A pause can likewise be requested while a beat is in flight, and the status bit must then wait until `beatBusy` falls.

// File: rtl/drr_pkg.sv
package drr_pkg;
  localparam int AW = 16;
  localparam logic [AW-1:0] TBL_BASE = 16'h2000;
  localparam logic [AW-1:0] CH_BASE  = 16'h1000;
  localparam int CH_SHIFT = 6;

  typedef struct packed {
    logic          tblWe;
    logic          pauseWe;
    logic [AW-1:0] wrIdx;
    logic          rdTbl;
    logic          rdPause;
    logic [AW-1:0] rdIdx;
  } strobe_t;
endpackage

// File: rtl/drr_decode.sv
module drr_decode
  import drr_pkg::*;
#(
  parameter int NUM_IDS = 16,
  parameter int NUM_CH  = 8
) (
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [AW-1:0] rdAddr,
  output strobe_t       stb
);
  localparam logic [AW-1:0] TBL_END = AW'(int'(TBL_BASE) + 4 * NUM_IDS);
  localparam logic [AW-1:0] CH_END  = AW'(int'(CH_BASE) + (NUM_CH << CH_SHIFT));

  logic [AW-1:0] wOffT, wOffC, rOffT, rOffC;
  logic wInT, wInC, rInT, rInC;

  always_comb begin
    wOffT = wrAddr - TBL_BASE;
    wOffC = wrAddr - CH_BASE;
    rOffT = rdAddr - TBL_BASE;
    rOffC = rdAddr - CH_BASE;
    wInT = (wrAddr >= TBL_BASE) && (wrAddr < TBL_END) && (wOffT[1:0] == 2'b00);
    wInC = (wrAddr >= CH_BASE) && (wrAddr < CH_END) && (wOffC[CH_SHIFT-1:0] == '0);
    rInT = (rdAddr >= TBL_BASE) && (rdAddr < TBL_END) && (rOffT[1:0] == 2'b00);
    rInC = (rdAddr >= CH_BASE) && (rdAddr < CH_END) && (rOffC[CH_SHIFT-1:0] == '0);

    stb.tblWe   = wrEn && wInT;
    stb.pauseWe = wrEn && wInC;
    stb.wrIdx   = wInT ? (wOffT >> 2) : (wOffC >> CH_SHIFT);
    stb.rdTbl   = rInT;
    stb.rdPause = rInC;
    stb.rdIdx   = rInT ? (rOffT >> 2) : (rOffC >> CH_SHIFT);
  end
endmodule

// File: rtl/drr_datapath.sv
module drr_datapath
  import drr_pkg::*;
#(
  parameter int NUM_IDS = 16,
  parameter int NUM_CH  = 8,
  parameter int CW      = 4,
  parameter int DW      = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  strobe_t            stb,
  input  logic [DW-1:0]      wrData,
  output logic [DW-1:0]      rdData,
  input  logic [NUM_IDS-1:0] periphReq,
  input  logic [NUM_CH-1:0]  chEnable,
  input  logic [NUM_CH-1:0]  beatBusy,
  output logic [NUM_CH-1:0]  chTrig,
  output logic [NUM_CH-1:0]  pauseReq,
  output logic [NUM_CH-1:0]  pauseStat
);
  logic [CW-1:0]     mapReg [NUM_IDS];
  logic [NUM_CH-1:0] hit;

  for (genvar i = 0; i < NUM_IDS; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) mapReg[i] <= '0;
      else if (stb.tblWe && stb.wrIdx == AW'(i)) mapReg[i] <= wrData[CW-1:0];
    end
  end

  always_comb begin
    hit = '0;
    for (int i = 0; i < NUM_IDS; i++)
      for (int c = 0; c < NUM_CH; c++)
        if (periphReq[i] && mapReg[i] == CW'(c + 1)) hit[c] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) chTrig <= '0;
    else     chTrig <= hit & chEnable;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_pause
    always_ff @(posedge clk) begin
      if (rst) begin
        pauseReq[c]  <= 1'b0;
        pauseStat[c] <= 1'b0;
      end else begin
        if (stb.pauseWe && stb.wrIdx == AW'(c)) pauseReq[c] <= wrData[0];
        pauseStat[c] <= pauseReq[c] && (pauseStat[c] || !beatBusy[c]);
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (stb.rdTbl) begin
      for (int i = 0; i < NUM_IDS; i++)
        if (stb.rdIdx == AW'(i)) rdData[CW-1:0] = mapReg[i];
    end else if (stb.rdPause) begin
      for (int c = 0; c < NUM_CH; c++)
        if (stb.rdIdx == AW'(c)) begin
          rdData[0] = pauseReq[c];
          rdData[2] = pauseStat[c];
        end
    end
  end
endmodule

// File: rtl/dma_req_router.sv
module dma_req_router
  import drr_pkg::*;
#(
  parameter int NUM_IDS = 16,
  parameter int NUM_CH  = 8,
  localparam int CW = $clog2(NUM_CH + 1),
  localparam int DW = (CW > 3) ? CW : 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wrEn,
  input  logic [AW-1:0]      wrAddr,
  input  logic [DW-1:0]      wrData,
  input  logic [AW-1:0]      rdAddr,
  output logic [DW-1:0]      rdData,
  input  logic [NUM_IDS-1:0] periphReq,
  input  logic [NUM_CH-1:0]  chEnable,
  input  logic [NUM_CH-1:0]  beatBusy,
  output logic [NUM_CH-1:0]  chTrig,
  output logic [NUM_CH-1:0]  pauseReq
);
  strobe_t           stb;
  logic [NUM_CH-1:0] pauseStat;

  drr_decode #(.NUM_IDS(NUM_IDS), .NUM_CH(NUM_CH)) u_dec (
    .wrEn(wrEn), .wrAddr(wrAddr), .rdAddr(rdAddr), .stb(stb)
  );

  drr_datapath #(.NUM_IDS(NUM_IDS), .NUM_CH(NUM_CH), .CW(CW), .DW(DW)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .wrData(wrData), .rdData(rdData),
    .periphReq(periphReq), .chEnable(chEnable), .beatBusy(beatBusy),
    .chTrig(chTrig), .pauseReq(pauseReq), .pauseStat(pauseStat)
  );
endmodule

// File: rtl/dma_req_router_chk.sv
module dma_req_router_chk #(
  parameter int NUM_IDS = 16,
  parameter int NUM_CH  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_IDS-1:0] periphReq,
  input logic [NUM_CH-1:0]  chEnable,
  input logic [NUM_CH-1:0]  beatBusy,
  input logic [NUM_CH-1:0]  chTrig,
  input logic [NUM_CH-1:0]  pauseReq,
  input logic [NUM_CH-1:0]  pauseStat
);
  // R7
  trig_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (chTrig & ~$past(chEnable)) == '0);

  // R3
  no_req_no_trig_chk: assert property (@(posedge clk) disable iff (rst)
    (periphReq == '0) |=> (chTrig == '0));

  // R9
  stat_rise_after_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (pauseStat & ~$past(pauseStat) & ~($past(pauseReq) & ~$past(beatBusy))) == '0);

  // R10
  stat_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    (pauseStat & ~$past(pauseReq)) == '0);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (chTrig == '0 && pauseReq == '0 && pauseStat == '0));
endmodule

bind dma_req_router dma_req_router_chk #(.NUM_IDS(NUM_IDS), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .periphReq(periphReq), .chEnable(chEnable),
  .beatBusy(beatBusy), .chTrig(chTrig), .pauseReq(pauseReq), .pauseStat(pauseStat)
);

// File: tb/sim_dma_req_router.sv
module sim_dma_req_router;
  localparam int NI = 16;
  localparam int NC = 8;
  localparam int DW = 4;

  logic clk = 0, rst = 1;
  logic wrEn = 0;
  logic [15:0] wrAddr = '0, rdAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic [NI-1:0] periphReq = '0;
  logic [NC-1:0] chEnable = '0, beatBusy = '0;
  logic [NC-1:0] chTrig, pauseReq;

  int errors = 0, checks = 0, cycNow = 0;

  typedef struct { int cyc; logic [NC-1:0] exp; string tag; } item_t;
  item_t sb[$];

  dma_req_router #(.NUM_IDS(NI), .NUM_CH(NC)) u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .periphReq(periphReq),
    .chEnable(chEnable), .beatBusy(beatBusy), .chTrig(chTrig), .pauseReq(pauseReq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cycNow <= cycNow + 1;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares chTrig once per cycle against the queued expectation
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].cyc < cycNow) begin
      item_t it;
      it = sb.pop_front();
      check(it.tag, int'(chTrig), int'(it.exp));
    end
  end

  function automatic logic [15:0] tblA(int id);
    return 16'(32'h2000 + 4 * (id - 1));
  endfunction
  function automatic logic [15:0] chA(int c);
    return 16'(32'h1000 + 64 * c);
  endfunction

  // driver: one clock cycle of stimulus plus the trigger vector it must give
  task automatic cyc(logic we, logic [15:0] a, int d, logic [NI-1:0] req,
                     logic [NC-1:0] exp, string tag);
    @(negedge clk);
    wrEn = we; wrAddr = a; wrData = DW'(d); periphReq = req;
    sb.push_back('{cycNow, exp, tag});
    @(posedge clk);
    #1 wrEn = 0;
  endtask

  task automatic wr(logic [15:0] a, int d, string tag);
    cyc(1'b1, a, d, '0, '0, tag);
  endtask
  task automatic idle(string tag);
    cyc(1'b0, '0, 0, '0, '0, tag);
  endtask
  task automatic rdChk(logic [15:0] a, int exp, string tag);
    rdAddr = a;
    #1 check(tag, int'(rdData), exp);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    rdChk(tblA(1), 0, "R1 entry1");
    rdChk(tblA(16), 0, "R1 entry16");
    rdChk(chA(0), 0, "R1 pause0");
    check("R1 chTrig", int'(chTrig), 0);
    check("R1 pauseReq", int'(pauseReq), 0);
    chEnable = '1;

    // R2 write and readback
    wr(tblA(3), 6, "R2 wr3");
    rdChk(tblA(3), 6, "R2 rd3");
    wr(tblA(16), 2, "R2 wr16");
    rdChk(tblA(16), 2, "R2 rd16");

    // R3 forwarding
    cyc(1'b0, '0, 0, NI'(1 << 2), NC'(1 << 5), "R3 id3->ch5");
    cyc(1'b0, '0, 0, NI'(1 << 15), NC'(1 << 1), "R3 id16->ch1");
    idle("R3 quiet");

    // R4 unmapped and removed mapping
    cyc(1'b0, '0, 0, NI'(1 << 4), '0, "R4 id5 unmapped");
    wr(tblA(3), 0, "R4 clear3");
    cyc(1'b0, '0, 0, NI'(1 << 2), '0, "R4 id3 removed");

    // R5 no entry for ID 0
    wr(16'h1FFC, 7, "R5 wr id0");
    rdChk(16'h1FFC, 0, "R5 rd id0");
    cyc(1'b0, '0, 0, NI'(1), '0, "R5 bit0 is id1");

    // R2 same-cycle write and request: old mapping first
    cyc(1'b1, tblA(4), 1, NI'(1 << 3), '0, "R2 same-cycle old map");
    cyc(1'b0, '0, 0, NI'(1 << 3), NC'(1), "R2 new map next cycle");

    // R6 merge
    wr(tblA(7), 4, "R6 wr7");
    wr(tblA(8), 4, "R6 wr8");
    cyc(1'b0, '0, 0, NI'(1 << 6), NC'(1 << 3), "R6 id7");
    cyc(1'b0, '0, 0, NI'(1 << 7), NC'(1 << 3), "R6 id8");
    cyc(1'b0, '0, 0, NI'((1 << 6) | (1 << 7) | (1 << 15)), NC'(8'h0A), "R6 both plus id16");

    // R7 disabled channel drops
    chEnable = ~NC'(1 << 3);
    cyc(1'b0, '0, 0, NI'(1 << 6), '0, "R7 disabled");
    chEnable = '1;
    idle("R7 not deferred");

    // R11 out-of-range values
    wr(tblA(9), 9, "R11 wr9");
    rdChk(tblA(9), 9, "R11 rd9");
    wr(tblA(10), 15, "R11 wr10");
    cyc(1'b0, '0, 0, NI'((1 << 8) | (1 << 9)), '0, "R11 no route");

    // R8 R9 pause while a beat is in flight
    beatBusy = NC'(1 << 2);
    wr(chA(2), 1, "R8 pause2");
    check("R8 pauseReq", int'(pauseReq), 32'h04);
    rdChk(chA(2), 1, "R8 rd pause2");
    idle("R9 busy1");
    rdChk(chA(2), 1, "R9 held off");
    beatBusy = '0;
    idle("R9 idle");
    rdChk(chA(2), 5, "R9 paused");

    // R10 resume
    wr(chA(2), 0, "R10 resume");
    check("R10 pauseReq", int'(pauseReq), 0);
    rdChk(chA(2), 4, "R10 stat lingers");
    idle("R10 wait");
    rdChk(chA(2), 0, "R10 stat clear");

    // R9 pause on an idle channel
    wr(chA(7), 1, "R9 pause7");
    rdChk(chA(7), 1, "R9 rd7 first");
    idle("R9 wait7");
    rdChk(chA(7), 5, "R9 rd7 paused");

    idle("drain");
    @(negedge clk);
    #1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule